// File: doc/BRIEF.md
# Deferred Status Flag Evaluator

This unit supplies the zero, carry and test flags of a processor without computing them at the end of the arithmetic cycle. When a flag-altering instruction completes, the unit stores a snapshot of the raw ALU result, the carry out and a three-bit condition selector. During every later cycle the flags are decoded combinationally from that snapshot. The ALU cycle can therefore end as soon as its output is valid, and the wide zero detect and the condition decode move to the start of the next cycle. There they are still early enough for a branch or select instruction that samples the test flag late in its execute cycle.

Instructions that do not alter flags, such as register moves, loads and stores, leave the snapshot untouched, so the flags persist across them. Because the status register exists only as a decoded view, a status register write cannot load flag bits directly. Instead it writes an override snapshot: a result that is zero exactly when the written Z bit is set, the written carry, and a selector of "always" or "never" that reproduces the written T bit.

Top module: `deferred_flag_unit`

## Requirements
- R1: When `flag_upd` is high and `sr_wr` is low at a rising edge, `z_flag` is 1 from that edge on exactly when the captured `alu_result` was zero.
- R2: Under the same condition, `c_flag` equals the captured `alu_cout` from that edge on.
- R3: With `flag_upd` and `sr_wr` both low at an edge, `z_flag`, `c_flag`, `t_flag` and `sr_rdata` keep their values.
- R4: `t_flag` is derived from the captured `cond_code` applied to the stored flags: 0 Z set, 1 Z clear, 2 C set, 3 C clear, 6 always 1, 7 always 0.
- R5: `sr_rdata` bit 0 is `z_flag`, bit 1 is `c_flag` and bit 2 is `t_flag`, with the same layout used by `sr_wdata`.
- R6: A write (`sr_wr` high at an edge) makes `sr_rdata` equal the written `sr_wdata` from that edge on, and the written value persists until the next update or write.
- R7: When `sr_wr` and `flag_upd` are both high at the same edge, the write takes effect and the ALU inputs are ignored.
- R8: While `rst_n` is low, `z_flag` is 1, `c_flag` is 0 and `t_flag` is 0 (`sr_rdata` = 3'b001).
- R9: Condition codes 4 and 5 give `t_flag` equal to the most significant bit of the stored result, and its inverse, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flag_upd | input | 1 | A flag-altering instruction ends in this cycle |
| alu_result | input | DATA_W | Raw ALU result to capture |
| alu_cout | input | 1 | ALU carry out to capture |
| cond_code | input | 3 | Condition selector for the test flag |
| sr_wr | input | 1 | Status register write (restore) |
| sr_wdata | input | 3 | Value written: {T, C, Z} |
| z_flag | output | 1 | Derived zero flag |
| c_flag | output | 1 | Derived carry flag |
| t_flag | output | 1 | Derived test flag |
| sr_rdata | output | 3 | Status register view: {T, C, Z} |

## Verification
The bench builds the unit with an eight-bit data width instead of the default sixteen. With the narrower result a random operand hits zero and has its sign bit set often, so the zero detect and the sign-based conditions are covered along with the carry ones in one short run. Write-over-update collisions, restores followed by idle cycles, and all eight condition codes are driven both directly and at random.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

    typedef enum logic [2:0] {
        CC_EQ     = 3'd0,
        CC_NE     = 3'd1,
        CC_ULT    = 3'd2,
        CC_UGE    = 3'd3,
        CC_LT     = 3'd4,
        CC_GE     = 3'd5,
        CC_ALWAYS = 3'd6,
        CC_NEVER  = 3'd7
    } cc_e;

    localparam int SR_W   = 3;
    localparam int SR_Z   = 0;
    localparam int SR_C   = 1;
    localparam int SR_T   = 2;

endpackage

// File: rtl/dfe_snapshot.sv
module dfe_snapshot
    import dfe_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [DATA_W-1:0] res_in,
    input  logic              carry_in,
    input  logic [2:0]        cc_in,
    input  logic              wr_en,
    input  logic [SR_W-1:0]   wr_val,
    output logic [DATA_W-1:0] snap_res,
    output logic              snap_carry,
    output logic [2:0]        snap_cc
);

    localparam logic [DATA_W-1:0] NONZERO = {{(DATA_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              carry;
        logic [2:0]        cc;
    } snap_t;

    snap_t snap_d, snap_q;

    always_comb begin
        snap_d = snap_q;
        if (wr_en) begin
            snap_d.res   = wr_val[SR_Z] ? '0 : NONZERO;
            snap_d.carry = wr_val[SR_C];
            snap_d.cc    = wr_val[SR_T] ? CC_ALWAYS : CC_NEVER;
        end else if (upd_en) begin
            snap_d.res   = res_in;
            snap_d.carry = carry_in;
            snap_d.cc    = cc_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q.res   <= '0;
            snap_q.carry <= 1'b0;
            snap_q.cc    <= CC_NEVER;
        end else begin
            snap_q <= snap_d;
        end
    end

    assign snap_res   = snap_q.res;
    assign snap_carry = snap_q.carry;
    assign snap_cc    = snap_q.cc;

    // R7
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && upd_en) |=> (snap_cc == CC_ALWAYS || snap_cc == CC_NEVER));

    // R6
    restore_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((snap_res == '0) == $past(wr_val[SR_Z])));

endmodule

// File: rtl/dfe_derive.sv
module dfe_derive
    import dfe_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] snap_res,
    input  logic              snap_carry,
    input  logic [2:0]        snap_cc,
    output logic              z_o,
    output logic              c_o,
    output logic              t_o
);

    localparam int MSB = DATA_W - 1;

    logic zero_w;
    logic sign_w;

    always_comb begin
        zero_w = ~|snap_res;
        sign_w = snap_res[MSB];
        unique case (cc_e'(snap_cc))
            CC_EQ:     t_o = zero_w;
            CC_NE:     t_o = ~zero_w;
            CC_ULT:    t_o = snap_carry;
            CC_UGE:    t_o = ~snap_carry;
            CC_LT:     t_o = sign_w;
            CC_GE:     t_o = ~sign_w;
            CC_ALWAYS: t_o = 1'b1;
            default:   t_o = 1'b0;
        endcase
        z_o = zero_w;
        c_o = snap_carry;
    end

endmodule

// File: rtl/deferred_flag_unit.sv
module deferred_flag_unit
    import dfe_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_upd,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_cout,
    input  logic [2:0]        cond_code,
    input  logic              sr_wr,
    input  logic [2:0]        sr_wdata,
    output logic              z_flag,
    output logic              c_flag,
    output logic              t_flag,
    output logic [2:0]        sr_rdata
);

    logic [DATA_W-1:0] snap_res;
    logic              snap_carry;
    logic [2:0]        snap_cc;

    dfe_snapshot #(.DATA_W(DATA_W)) u_snap (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_en     (flag_upd),
        .res_in     (alu_result),
        .carry_in   (alu_cout),
        .cc_in      (cond_code),
        .wr_en      (sr_wr),
        .wr_val     (sr_wdata),
        .snap_res   (snap_res),
        .snap_carry (snap_carry),
        .snap_cc    (snap_cc)
    );

    dfe_derive #(.DATA_W(DATA_W)) u_derive (
        .snap_res   (snap_res),
        .snap_carry (snap_carry),
        .snap_cc    (snap_cc),
        .z_o        (z_flag),
        .c_o        (c_flag),
        .t_o        (t_flag)
    );

    always_comb begin
        sr_rdata        = '0;
        sr_rdata[SR_Z]  = z_flag;
        sr_rdata[SR_C]  = c_flag;
        sr_rdata[SR_T]  = t_flag;
    end

    // R1
    zero_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd && !sr_wr) |=> (z_flag == ($past(alu_result) == '0)));

    // R2
    carry_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd && !sr_wr) |=> (c_flag == $past(alu_cout)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_upd && !sr_wr) |=> $stable(sr_rdata));

    // R4
    always_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd && !sr_wr && cond_code == CC_ALWAYS) |=> t_flag);

    // R6
    restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr |=> (sr_rdata == $past(sr_wdata)));

    // R8
    reset_chk: assert property (@(posedge clk)
        !rst_n |=> (sr_rdata == 3'b001));

endmodule

// File: tb/sim_deferred_flag_unit.sv
module sim_deferred_flag_unit;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flag_upd = 1'b0;
    logic [W-1:0] alu_result = '0;
    logic         alu_cout = 1'b0;
    logic [2:0]   cond_code = 3'd0;
    logic         sr_wr = 1'b0;
    logic [2:0]   sr_wdata = 3'd0;
    logic         z_flag, c_flag, t_flag;
    logic [2:0]   sr_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int exp_z = 1, exp_c = 0, exp_t = 0;
    string tag_z = "R8", tag_c = "R8", tag_t = "R8", tag_sr = "R8";

    always #10 clk = ~clk;

    deferred_flag_unit #(.DATA_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .flag_upd(flag_upd), .alu_result(alu_result),
        .alu_cout(alu_cout), .cond_code(cond_code), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
        .z_flag(z_flag), .c_flag(c_flag), .t_flag(t_flag), .sr_rdata(sr_rdata)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(tag_z, int'(z_flag), exp_z);
        check(tag_c, int'(c_flag), exp_c);
        check(tag_t, int'(t_flag), exp_t);
        check(tag_sr, int'(sr_rdata), exp_t * 4 + exp_c * 2 + exp_z);
    endtask

    function automatic int cond_eval(input int cc, input int z, input int c, input int neg);
        case (cc)
            0: return z;
            1: return 1 - z;
            2: return c;
            3: return 1 - c;
            4: return neg;
            5: return 1 - neg;
            6: return 1;
            default: return 0;
        endcase
    endfunction

    // One cycle: check results of the previous cycle, then drive and predict.
    task automatic step(input bit upd, input int res, input bit cy, input int cc,
                        input bit wr, input int wd);
        @(negedge clk);
        compare_all();
        flag_upd   = upd;
        alu_result = W'(res);
        alu_cout   = cy;
        cond_code  = 3'(cc);
        sr_wr      = wr;
        sr_wdata   = 3'(wd);
        if (wr) begin
            exp_z = wd % 2;
            exp_c = (wd / 2) % 2;
            exp_t = (wd / 4) % 2;
            tag_z = upd ? "R7" : "R6"; tag_c = tag_z; tag_t = tag_z; tag_sr = tag_z;
        end else if (upd) begin
            exp_z = ((res % 256) == 0) ? 1 : 0;
            exp_c = cy;
            exp_t = cond_eval(cc, exp_z, exp_c, ((res % 256) >= 128) ? 1 : 0);
            tag_z = "R1"; tag_c = "R2";
            tag_t = (cc == 4 || cc == 5) ? "R9" : "R4";
            tag_sr = "R5";
        end else begin
            tag_z = "R3"; tag_c = "R3"; tag_t = "R3"; tag_sr = "R3";
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        compare_all();
        rst_n = 1'b1;
        // R1 R2 R4 directed
        step(1, 0,   1, 0, 0, 0);
        step(1, 5,   0, 0, 0, 0);
        step(1, 5,   0, 1, 0, 0);
        step(1, 0,   1, 2, 0, 0);
        step(1, 0,   1, 3, 0, 0);
        // R9 sign conditions
        step(1, 128, 0, 4, 0, 0);
        step(1, 127, 0, 4, 0, 0);
        step(1, 200, 0, 5, 0, 0);
        step(1, 1,   1, 6, 0, 0);
        step(1, 0,   1, 7, 0, 0);
        // R3 persistence across non-flag instructions
        step(0, 0,   0, 0, 0, 0);
        step(0, 99,  1, 6, 0, 0);
        step(0, 0,   0, 7, 0, 0);
        // R6 restore and persistence
        step(0, 0, 0, 0, 1, 3'b101);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 3'b010);
        step(0, 7, 1, 6, 0, 0);
        step(0, 0, 0, 0, 1, 3'b111);
        step(0, 0, 0, 0, 1, 3'b000);
        // R7 write beats update
        step(1, 0, 1, 6, 1, 3'b000);
        step(1, 77, 0, 7, 1, 3'b111);
        step(0, 0, 0, 0, 0, 0);
        // Random mix
        for (int i = 0; i < 400; i++) begin
            int r  = $urandom_range(0, 3) == 0 ? 0 : int'($urandom_range(0, 255));
            bit u  = ($urandom_range(0, 2) != 0);
            bit wq = ($urandom_range(0, 7) == 0);
            step(u, r, 1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
                 wq, int'($urandom_range(0, 7)));
        end
        @(negedge clk);
        compare_all();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule